// File: doc/BRIEF.md
# SMBus Register-File Target

This block is the device-side responder of an SMBus target that exposes a small register file. A byte-level bus slave, which is not part of this block, does the bit timing. It passes the block one-cycle strobes: an address byte with its direction, each byte written by the master, a request for the next byte to transmit, the master's acknowledge or not-acknowledge after a transmitted byte, a repeated start and a stop. The block returns an acknowledge decision for the address or byte it is shown in that cycle. It also returns the byte to transmit and a flag that says whether it still has bytes to send.

The first byte written after the block's own address is a command. Its low bits select the starting register and its top bit selects block mode. Later written bytes fill registers from the pointer onward, and the pointer advances after each one. Every read starts at the register chosen by the most recent command, including a read that no command precedes. This single rule covers the byte, byte-data, word-data, process-call and block accesses. In block mode the first written byte is a length. A block read opens with a count byte that the device produces itself.

Top module: `smbus_regdev`

## Requirements
- R1: `ack` is 1 in a cycle where `addr_valid` presents `DEV_ADDR` in either direction. `ack` is 1 for every byte written while addressed for write, except block bytes past the limit in R9. A foreign address gets `ack`=0, and bytes that follow it get `ack`=0 and change no register.
- R2: The first byte written after the own write address is the command. Bits [AW-1:0] select the register (AW = log2 DEPTH) and bit 7 set selects block mode.
- R3: Each further non-block byte is stored at the pointer, and then the pointer advances by one modulo DEPTH. Each new command restores the pointer to the command's register.
- R4: A read address loads the pointer from the last command, so a read with no command in its own transaction returns the register that the previous command selected.
- R5: Word accesses carry the low byte at the command register and the high byte at the next register, low byte first in both directions.
- R6: Process call: after a command and two data bytes, a repeated start with a read returns those two bytes in the order they were written.
- R7: `tx_valid` stays 1 after each byte that the master acknowledges (`mack`=1). It is 0 from the cycle after a not-acknowledge onward.
- R8: A block-mode read first sends the count byte `BLK_COUNT`, then `BLK_COUNT` register bytes from the pointer upward, then 0xFF.
- R9: In a block write, the byte after the command is the length. Data bytes up to min(length, 32) are acknowledged and stored. Any further bytes get `ack`=0 and are not stored.
- R10: A stop or repeated start ends the transaction (`tx_valid`=0) and keeps the last command.
- R11: After reset all registers are 0, the command is 0 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_valid | input | 1 | Address byte received strobe |
| addr | input | 7 | Received target address |
| addr_rd | input | 1 | Direction bit of the address, 1 = read |
| rx_valid | input | 1 | Written byte received strobe |
| rx_data | input | 8 | Written byte |
| tx_req | input | 1 | Transmit byte taken strobe |
| mack_valid | input | 1 | Master acknowledge bit strobe |
| mack | input | 1 | 1 = master acknowledged, 0 = not |
| rstart | input | 1 | Repeated start seen |
| stop | input | 1 | Stop seen |
| ack | output | 1 | Acknowledge the address or byte shown this cycle |
| tx_valid | output | 1 | Device has a byte to send |
| tx_data | output | 8 | Byte to send next |

## Verification
The assertions check on every cycle that a foreign address is never acknowledged and that stops and repeated starts keep the command. They also check that transmission ends after a stop or a not-acknowledge, that a command write reloads the pointer, and that the block length counter never exceeds 32. Only the bench scenarios can show the data path. That covers what each access stores and returns, the low-byte-first order, pointer wrap, and the block count byte with its trailing filler. It also covers the cap at 32 bytes and the fact that foreign traffic leaves the registers untouched, all compared against a register model held in the bench.

// File: rtl/smbus_regdev.sv
module smbus_regdev #(
  parameter int DEPTH = 8,
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int BLK_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_valid,
  input  logic [6:0] addr,
  input  logic       addr_rd,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_req,
  input  logic       mack_valid,
  input  logic       mack,
  input  logic       rstart,
  input  logic       stop,
  output logic       ack,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int MAX_BLK = 32;

  logic [7:0]    regs [DEPTH];
  logic [7:0]    cmd_q;
  logic [AW-1:0] ptr_q;
  logic          active_q, rd_q, first_q, blk_q, cnt_pend_q, send_q;
  logic [5:0]    left_q;

  wire own    = addr_valid && (addr == DEV_ADDR);
  wire wr_ok  = rx_valid && active_q && !rd_q;
  wire is_cmd = wr_ok && first_q;
  wire is_len = wr_ok && !first_q && blk_q && cnt_pend_q;
  wire is_dat = wr_ok && !first_q && !(blk_q && cnt_pend_q) && (!blk_q || left_q != 6'd0);

  assign ack      = own || is_cmd || is_len || is_dat;
  assign tx_valid = active_q && rd_q && send_q;
  assign tx_data  = (blk_q && cnt_pend_q) ? 8'(BLK_COUNT) :
                    (blk_q && left_q == 6'd0) ? 8'hFF : regs[ptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; ptr_q <= '0; left_q <= '0;
      active_q <= 1'b0; rd_q <= 1'b0; first_q <= 1'b0;
      blk_q <= 1'b0; cnt_pend_q <= 1'b0; send_q <= 1'b0;
    end else if (stop || rstart) begin
      active_q <= 1'b0;
      send_q   <= 1'b0;
    end else if (addr_valid) begin
      active_q <= own;
      rd_q     <= addr_rd;
      first_q  <= !addr_rd;
      send_q   <= own && addr_rd;
      if (own && addr_rd) begin
        ptr_q      <= cmd_q[AW-1:0];
        blk_q      <= cmd_q[7];
        cnt_pend_q <= cmd_q[7];
        left_q     <= 6'(BLK_COUNT);
      end
    end else if (is_cmd) begin
      cmd_q      <= rx_data;
      ptr_q      <= rx_data[AW-1:0];
      blk_q      <= rx_data[7];
      cnt_pend_q <= rx_data[7];
      first_q    <= 1'b0;
    end else if (is_len) begin
      left_q     <= (rx_data > 8'(MAX_BLK)) ? 6'(MAX_BLK) : rx_data[5:0];
      cnt_pend_q <= 1'b0;
    end else if (is_dat) begin
      ptr_q <= ptr_q + 1'b1;
      if (blk_q) left_q <= left_q - 1'b1;
    end else if (tx_req && tx_valid) begin
      if (blk_q && cnt_pend_q) cnt_pend_q <= 1'b0;
      else if (!blk_q) ptr_q <= ptr_q + 1'b1;
      else if (left_q != 6'd0) begin
        ptr_q  <= ptr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end else if (mack_valid && !mack) begin
      send_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (is_dat && !stop && !rstart && !addr_valid) begin
      regs[ptr_q] <= rx_data;
    end
  end
endmodule

module smbus_regdev_chk #(
  parameter int AW = 3,
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic [6:0]    addr,
  input logic          rx_valid,
  input logic [7:0]    rx_data,
  input logic          mack_valid,
  input logic          mack,
  input logic          rstart,
  input logic          stop,
  input logic          ack,
  input logic          tx_valid,
  input logic [7:0]    cmd_q,
  input logic [AW-1:0] ptr_q,
  input logic [5:0]    left_q,
  input logic          first_q,
  input logic          active_q,
  input logic          rd_q
);
  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr != DEV_ADDR |-> !ack); // R1
  AST_CMD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop || rstart) |=> cmd_q == $past(cmd_q)); // R10
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !tx_valid); // R10
  AST_NACK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    mack_valid && !mack && !addr_valid |=> !tx_valid); // R7
  AST_PTR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && active_q && !rd_q && first_q && !stop && !rstart && !addr_valid
    |=> ptr_q == $past(rx_data[AW-1:0])); // R3
  AST_BLK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= 6'd32); // R9
endmodule

bind smbus_regdev smbus_regdev_chk #(.AW(AW), .DEV_ADDR(DEV_ADDR)) chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
  .rx_valid(rx_valid), .rx_data(rx_data), .mack_valid(mack_valid), .mack(mack),
  .rstart(rstart), .stop(stop), .ack(ack), .tx_valid(tx_valid),
  .cmd_q(cmd_q), .ptr_q(ptr_q), .left_q(left_q), .first_q(first_q),
  .active_q(active_q), .rd_q(rd_q));

// File: tb/smbus_regdev_test.sv
module smbus_regdev_test;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int BLKC = 4;

  logic clk = 0, rst_n = 0;
  logic addr_valid = 0, addr_rd = 0, rx_valid = 0, tx_req = 0;
  logic mack_valid = 0, mack = 0, rstart = 0, stop = 0;
  logic [6:0] addr = 0;
  logic [7:0] rx_data = 0;
  logic ack, tx_valid;
  logic [7:0] tx_data;
  logic [7:0] model [8];
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  smbus_regdev uut (.clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
    .addr_rd(addr_rd), .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req),
    .mack_valid(mack_valid), .mack(mack), .rstart(rstart), .stop(stop),
    .ack(ack), .tx_valid(tx_valid), .tx_data(tx_data));

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_addr(input logic [6:0] a, input logic rd, input logic exp, input string tag);
    @(negedge clk); addr_valid = 1; addr = a; addr_rd = rd;
    #1 check(ack === exp, tag, {7'd0, ack}, {7'd0, exp});
    @(posedge clk); #1 addr_valid = 0;
  endtask

  task automatic do_wr(input logic [7:0] d, input logic exp, input string tag);
    @(negedge clk); rx_valid = 1; rx_data = d;
    #1 check(ack === exp, tag, {7'd0, ack}, {7'd0, exp});
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic do_rd(input logic [7:0] exp, input logic m, input string tag);
    @(negedge clk); #1
    check(tx_valid === 1'b1 && tx_data === exp, tag, tx_data, exp);
    tx_req = 1; @(posedge clk); #1 tx_req = 0;
    @(negedge clk); mack_valid = 1; mack = m; @(posedge clk); #1 mack_valid = 0;
    if (!m) begin
      @(negedge clk); #1 check(tx_valid === 1'b0, "R7 tx_valid after NACK", {7'd0, tx_valid}, 8'd0);
    end
  endtask

  task automatic ev_stop;
    @(negedge clk); stop = 1; @(posedge clk); #1 stop = 0;
  endtask

  task automatic ev_rs;
    @(negedge clk); rstart = 1; @(posedge clk); #1 rstart = 0;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=00 expected=01");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R11 reset state
    @(negedge clk); #1 check(tx_valid === 1'b0, "R11 tx_valid after reset", {7'd0, tx_valid}, 8'd0);
    do_addr(DEV, 1, 1, "R11 read addr ack");
    do_rd(8'h00, 0, "R11 reg0 after reset");
    ev_stop();

    // R2 R3 byte data write sweep, R1 ack each byte
    for (int i = 0; i < 8; i++) begin
      do_addr(DEV, 0, 1, "R1 own write addr");
      do_wr(8'(i), 1, "R2 command ack");
      model[i] = 8'(8'h11 * i + 8'h05);
      do_wr(model[i], 1, "R1 data ack");
      ev_stop();
    end
    for (int i = 0; i < 8; i++) begin
      do_addr(DEV, 0, 1, "R1 own write addr");
      do_wr(8'(i), 1, "R2 command ack");
      ev_rs();
      do_addr(DEV, 1, 1, "R1 own read addr");
      do_rd(model[i], 0, "R2 byte data readback");
      ev_stop();
    end

    // R4 bare read after command-only write
    do_addr(DEV, 0, 1, "R1 own write addr");
    do_wr(8'h03, 1, "R2 command ack");
    ev_stop();
    do_addr(DEV, 1, 1, "R1 own read addr");
    do_rd(model[3], 0, "R4 bare read previous register");
    ev_stop();

    // R5 word write/read sweep with wrap, R7
    for (int i = 0; i < 8; i++) begin
      logic [7:0] lo, hi;
      lo = 8'(8'hA0 + i); hi = 8'(8'h3C ^ (i * 7));
      do_addr(DEV, 0, 1, "R1 own write addr");
      do_wr(8'(i), 1, "R2 command ack");
      do_wr(lo, 1, "R5 low ack");
      do_wr(hi, 1, "R5 high ack");
      model[i] = lo; model[(i + 1) % 8] = hi;
      ev_stop();
      do_addr(DEV, 0, 1, "R1 own write addr");
      do_wr(8'(i), 1, "R3 pointer restore");
      ev_rs();
      do_addr(DEV, 1, 1, "R1 own read addr");
      do_rd(lo, 1, "R5 word low first");
      @(negedge clk); #1 check(tx_valid === 1'b1, "R7 tx_valid after ACK", {7'd0, tx_valid}, 8'd1);
      do_rd(hi, 0, "R5 word high second");
      ev_stop();
    end

    // R6 process call
    do_addr(DEV, 0, 1, "R1 own write addr");
    do_wr(8'h05, 1, "R2 command ack");
    do_wr(8'h5A, 1, "R6 data0 ack");
    do_wr(8'hC3, 1, "R6 data1 ack");
    model[5] = 8'h5A; model[6] = 8'hC3;
    ev_rs();
    do_addr(DEV, 1, 1, "R1 own read addr");
    do_rd(8'h5A, 1, "R6 process call byte0");
    do_rd(8'hC3, 0, "R6 process call byte1");
    ev_stop();

    // R1 foreign address ignored
    do_addr(7'h11, 0, 0, "R1 foreign addr nack");
    do_wr(8'h02, 0, "R1 foreign byte nack");
    do_wr(8'h99, 0, "R1 foreign byte nack");
    ev_stop();
    do_addr(DEV, 0, 1, "R1 own write addr");
    do_wr(8'h02, 1, "R2 command ack");
    ev_rs();
    do_addr(DEV, 1, 1, "R1 own read addr");
    do_rd(model[2], 0, "R1 register untouched by foreign");
    ev_stop();

    // R9 block write length sweep, R8 block readback
    for (int n = 0; n < 6; n++) begin
      do_addr(DEV, 0, 1, "R1 own write addr");
      do_wr(8'h82, 1, "R2 block command ack");
      do_wr(8'(n), 1, "R9 length ack");
      for (int k = 0; k < n; k++) begin
        model[(2 + k) % 8] = 8'(8'h40 + n * 8 + k);
        do_wr(model[(2 + k) % 8], 1, "R9 block data ack");
      end
      do_wr(8'hEE, 0, "R9 excess byte nack");
      ev_stop();
      for (int s = 0; s < 8; s += 6) begin
        do_addr(DEV, 0, 1, "R1 own write addr");
        do_wr(8'(8'h80 | s), 1, "R2 block command ack");
        ev_rs();
        do_addr(DEV, 1, 1, "R1 own read addr");
        do_rd(8'(BLKC), 1, "R8 count byte");
        for (int k = 0; k < BLKC; k++) do_rd(model[(s + k) % 8], 1, "R8 block data");
        do_rd(8'hFF, 0, "R8 filler after count");
        ev_stop();
      end
    end
    do_addr(DEV, 0, 1, "R1 own write addr");
    do_wr(8'h82, 1, "R2 block command ack");
    do_wr(8'd40, 1, "R9 length ack");
    for (int k = 0; k < 32; k++) begin
      model[(2 + k) % 8] = 8'(8'h90 + k);
      do_wr(model[(2 + k) % 8], 1, "R9 capped data ack");
    end
    do_wr(8'h77, 0, "R9 byte 33 nack");
    ev_stop();
    do_addr(DEV, 0, 1, "R1 own write addr");
    do_wr(8'h80, 1, "R2 block command ack");
    ev_rs();
    do_addr(DEV, 1, 1, "R1 own read addr");
    do_rd(8'(BLKC), 1, "R8 count byte");
    for (int k = 0; k < BLKC; k++) do_rd(model[k], 1, "R9 capped block contents");
    // R10 stop mid-read ends transfer, command kept
    ev_stop();
    @(negedge clk); #1 check(tx_valid === 1'b0, "R10 stop idles", {7'd0, tx_valid}, 8'd0);
    do_addr(DEV, 1, 1, "R1 own read addr");
    do_rd(8'(BLKC), 1, "R10 command kept after stop");
    ev_stop();

    finish_run();
  end
endmodule